// File: doc/BRIEF.md
# Hand-Loaded ROM Port with Control Window

This block connects a byte-wide, dual-ported ROM image store to a 16-bit host device bus. The host bus carries a 28-bit address, a write strobe and 16-bit data in each direction. It is captured on the falling edge of the host clock. A second, read-only port on the system clock lets the emulated machine fetch the bytes the host has loaded.

The top 4K page of the device address space is reserved for control. Host accesses that fall in that page never reach the memory. Instead, they address a small status register, which is idle (0) after reset, and a parse-status location. The parse-status location always reports success (2), so that a host that polls for "success or error" after a load finishes at once.

Accesses outside the reserved page go to the memory through the low address bits. The bridge only acts when the device-select input carries its own id. The memory depth is a parameter: 15 address bits gives a 32 KB ROM, and the default is 10 bits.

Top module: `rom_csr_port`

## Requirements
- R1: A write whose address bits 27..12 are all ones (the control window) never changes any memory byte, whatever the low address bits are.
- R2: A selected read inside the window at word offset 0x010 returns 0x0002.
- R3: The status register reads 0x0000 after the active-low reset has been applied, including a reset applied after it held another value.
- R4: A selected write inside the window at offset 0x000 stores the full 16-bit write data in the status register, and a read at offset 0x000 returns it.
- R5: Reads at window offsets other than 0x000 and 0x010 return 0x0000. Writes to those offsets leave the status register unchanged.
- R6: Outside the window, a selected write stores the low 8 bits of the write data at the memory byte addressed by the low MEM_AW address bits. Higher address bits are ignored, so such addresses alias.
- R7: Outside the window, a selected read returns the addressed memory byte in bits 7..0, with bits 15..8 equal to 0x00.
- R8: When the device-select input differs from DEV_ID, the read data is 0x0000, and writes change neither the memory nor the status register.
- R9: The system port returns the memory byte at sys_addr on sys_rdata one sys_clk rising edge after the address is presented.
- R10: Host writes take effect on the falling edge of hclk. A value written in a cycle is not visible before that falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| hclk | input | 1 | Host bus clock; the bus is captured on its falling edge |
| hrst_n | input | 1 | Active-low asynchronous reset of the status register |
| dev_sel | input | 16 | Device id currently addressed by the host |
| haddr | input | 28 | Host device address |
| hwe | input | 1 | Host write strobe |
| hwdata | input | 16 | Host write data |
| hrdata | output | 16 | Host read data (combinational) |
| sys_clk | input | 1 | System clock for the machine-side read port |
| sys_addr | input | MEM_AW | Machine-side read address |
| sys_rdata | output | 8 | Machine-side read data, registered |

## Verification
The hardest case to reach is a window write whose low address bits coincide with a memory location that already holds known data. A bug that lets such a write through would only show as silent corruption of that one byte. The bench therefore fills every byte of a small 64-byte memory with distinct values first. It then writes to every window offset whose low bits cover all of those locations, and re-reads the whole memory. The falling-edge commit is checked by sampling the addressed byte between the rising and falling edges of the write cycle, and again after the falling edge.

// File: rtl/rom_csr_port.sv
module rom_csr_port #(
  parameter int          MEM_AW    = 10,
  parameter logic [15:0] DEV_ID    = 16'h0101,
  parameter logic [11:0] STAT_OFF  = 12'h000,
  parameter logic [11:0] PARSE_OFF = 12'h010,
  parameter logic [15:0] PARSE_OK  = 16'd2
) (
  input  logic              hclk,
  input  logic              hrst_n,
  input  logic [15:0]       dev_sel,
  input  logic [27:0]       haddr,
  input  logic              hwe,
  input  logic [15:0]       hwdata,
  output logic [15:0]       hrdata,
  input  logic              sys_clk,
  input  logic [MEM_AW-1:0] sys_addr,
  output logic [7:0]        sys_rdata
);
  localparam int DEPTH = 1 << MEM_AW;

  logic [7:0]        mem [DEPTH];
  logic [15:0]       stat_q;
  logic              sel, win, mem_we, stat_we;
  logic [11:0]       off;
  logic [MEM_AW-1:0] maddr;

  assign sel     = (dev_sel == DEV_ID);
  assign win     = (haddr[27:12] == 16'hFFFF);
  assign off     = haddr[11:0];
  assign maddr   = haddr[MEM_AW-1:0];
  assign mem_we  = sel & hwe & ~win;
  assign stat_we = sel & hwe & win & (off == STAT_OFF);

  always_ff @(negedge hclk)
    if (mem_we) mem[maddr] <= hwdata[7:0];

  always_ff @(negedge hclk or negedge hrst_n)
    if (!hrst_n)      stat_q <= 16'h0000;
    else if (stat_we) stat_q <= hwdata;

  always_comb begin
    if (!sel)                  hrdata = 16'h0000;
    else if (!win)             hrdata = {8'h00, mem[maddr]};
    else if (off == STAT_OFF)  hrdata = stat_q;
    else if (off == PARSE_OFF) hrdata = PARSE_OK;
    else                       hrdata = 16'h0000;
  end

  always_ff @(posedge sys_clk)
    sys_rdata <= mem[sys_addr];

  logic              chk_arm;
  logic [MEM_AW-1:0] chk_addr;
  logic [7:0]        chk_byte;

  always_ff @(negedge hclk or negedge hrst_n)
    if (!hrst_n) chk_arm <= 1'b0;
    else         chk_arm <= sel & hwe & win;

  always_ff @(negedge hclk) begin
    chk_addr <= maddr;
    chk_byte <= mem[maddr];
  end

  p_win_keeps_mem_r1: assert property (@(posedge hclk) disable iff (!hrst_n)
    chk_arm |-> (mem[chk_addr] == chk_byte));

  p_parse_ok_r2: assert property (@(posedge hclk) disable iff (!hrst_n)
    (sel && win && off == PARSE_OFF) |-> (hrdata == PARSE_OK));

  always @(posedge hclk)
    if (!hrst_n) p_stat_idle_r3: assert (stat_q == 16'h0000);

  p_stat_hold_r5: assert property (@(negedge hclk) disable iff (!hrst_n)
    !(sel && hwe && win && off == STAT_OFF) |=> $stable(stat_q));

  p_hi_zero_r7: assert property (@(posedge hclk) disable iff (!hrst_n)
    (sel && !win) |-> (hrdata[15:8] == 8'h00));

  p_unsel_quiet_r8: assert property (@(posedge hclk) disable iff (!hrst_n)
    !sel |-> (hrdata == 16'h0000));
endmodule

// File: tb/rom_csr_port_bench.sv
module rom_csr_port_bench;
  localparam int          AW  = 6;
  localparam int          N   = 1 << AW;
  localparam logic [15:0] ID  = 16'h0007;
  localparam logic [15:0] BAD = 16'h0008;
  localparam logic [27:0] WIN = 28'hFFFF000;

  logic          clk = 1'b0;
  logic          hrst_n = 1'b0;
  logic [15:0]   dev_sel = '0;
  logic [27:0]   haddr = '0;
  logic          hwe = 1'b0;
  logic [15:0]   hwdata = '0;
  logic [15:0]   hrdata;
  logic [AW-1:0] sys_addr = '0;
  logic [7:0]    sys_rdata;

  int checks = 0;
  int fails  = 0;
  logic [7:0]  model [N];
  logic [15:0] stat_m;

  always #4 clk = ~clk;

  rom_csr_port #(.MEM_AW(AW), .DEV_ID(ID)) u_rom_csr_port (
    .hclk(clk), .hrst_n(hrst_n), .dev_sel(dev_sel), .haddr(haddr),
    .hwe(hwe), .hwdata(hwdata), .hrdata(hrdata),
    .sys_clk(clk), .sys_addr(sys_addr), .sys_rdata(sys_rdata));

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [15:0] s, input logic [27:0] a,
                       input logic we, input logic [15:0] d);
    @(posedge clk); #1;
    dev_sel = s; haddr = a; hwe = we; hwdata = d;
  endtask

  task automatic wr(input logic [15:0] s, input logic [27:0] a, input logic [15:0] d);
    drive(s, a, 1'b1, d);
    @(negedge clk); #1;
    hwe = 1'b0;
  endtask

  task automatic rd(input string req, input logic [15:0] s, input logic [27:0] a,
                    input logic [15:0] exp);
    drive(s, a, 1'b0, 16'h0000);
    #2;
    check(req, hrdata, exp);
  endtask

  function automatic logic [7:0] pat(input int a, input int k);
    return 8'((a * 37 + k * 11 + 5) & 255);
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 hrst_n = 1'b1;
    // R3 reset value of the status register
    rd("R3", ID, WIN, 16'h0000);
    // R2 parse-status reads OK
    rd("R2", ID, WIN | 28'h010, 16'h0002);

    // R6 R7 fill and read every byte; junk in the high byte of the write data
    for (int a = 0; a < N; a++) begin
      model[a] = pat(a, 0);
      wr(ID, 28'(a), {8'hA5, model[a]});
    end
    for (int a = 0; a < N; a++) rd("R6_R7", ID, 28'(a), {8'h00, model[a]});

    // R6 aliasing: high address bits are ignored
    model[3] = 8'h5A;
    wr(ID, 28'h0100003, 16'hFF5A);
    rd("R6", ID, 28'h0000003, 16'h005A);
    rd("R6", ID, 28'h7A00003, 16'h005A);

    // R4 status write and readback
    wr(ID, WIN, 16'h1234);
    stat_m = 16'h1234;
    rd("R4", ID, WIN, stat_m);

    // R1 R5 window writes at every offset whose low bits cover the memory
    for (int o = 1; o < 2 * N; o++) wr(ID, WIN | 28'(o), 16'hC300 | 16'(o));
    for (int a = 0; a < N; a++) rd("R1", ID, 28'(a), {8'h00, model[a]});
    rd("R5", ID, WIN, stat_m);
    for (int o = 1; o < 2 * N; o++)
      if (o != 16) rd("R5", ID, WIN | 28'(o), 16'h0000);
    rd("R5", ID, WIN | 28'hFFF, 16'h0000);
    rd("R2", ID, WIN | 28'h010, 16'h0002);

    // R4 host writes idle back
    wr(ID, WIN, 16'h0000);
    stat_m = 16'h0000;
    rd("R4", ID, WIN, stat_m);
    wr(ID, WIN, 16'hBEEF);
    stat_m = 16'hBEEF;
    rd("R4", ID, WIN, stat_m);

    // R8 not selected
    rd("R8", BAD, 28'h0000009, 16'h0000);
    rd("R8", BAD, WIN, 16'h0000);
    rd("R8", BAD, WIN | 28'h010, 16'h0000);
    wr(BAD, 28'h0000009, 16'h00EE);
    wr(BAD, WIN, 16'h4444);
    rd("R8", ID, 28'h0000009, {8'h00, model[9]});
    rd("R8", ID, WIN, stat_m);

    // R9 system read port, one edge of latency
    for (int a = 0; a < N; a++) begin
      @(posedge clk); #1 sys_addr = AW'(a);
      @(posedge clk); #1;
      check("R9", {8'h00, sys_rdata}, {8'h00, model[a]});
    end

    // R10 write is committed at the falling edge
    drive(ID, 28'h0000005, 1'b1, {8'h00, ~model[5]});
    #2;
    check("R10", hrdata, {8'h00, model[5]});
    @(negedge clk); #1;
    check("R10", hrdata, {8'h00, ~model[5]});
    hwe = 1'b0;
    model[5] = ~model[5];

    // R3 reset after a non-idle value
    @(posedge clk); #1 hrst_n = 1'b0;
    #2;
    rd("R3", ID, WIN, 16'h0000);
    @(posedge clk); #1 hrst_n = 1'b1;
    rd("R3", ID, WIN, 16'h0000);
    rd("R6", ID, 28'h0000005, {8'h00, model[5]});

    summary();
  end
endmodule